// File: doc/BRIEF.md
# Scope Level and Pulse-Width Trigger

This block watches a stream of 10-bit converter samples and decides when a capture should trigger. It compares each accepted sample, and the one before it, against a programmed threshold, so it can spot crossings in either direction. In level mode a crossing in the chosen direction fires the trigger. In the two pulse modes a pulse opens on the chosen crossing and closes on the opposite one. The block counts how many samples the pulse lasted and fires either when the pulse was shorter than a programmed width or when it was at least that long. A fourth mode ignores the samples and passes through the rising edge of an external logic-combination trigger.

The host writes the configuration one byte at a time. One byte holds the low threshold bits. A control byte holds the top threshold bits, the edge polarity and the mode. A third byte holds the pulse width. The block produces a one-cycle trigger pulse and a sticky triggered flag, which the host clears with a strobe. Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is high whenever reset is released, and a sample counts only in a cycle where `s_valid` and `s_ready` are both high. Bubbles in the stream (cycles with `s_valid` low) are simply skipped and do not count as samples.

Top module: `scope_trigger`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` according to `cfg_addr`. Address 0 holds threshold bits [7:0]. Address 1 is the control byte: bits [1:0] are threshold bits [9:8], bit 2 set selects a falling edge (clear selects rising), and bits [6:5] select the mode (00 level, 01 pulse shorter than width, 10 pulse of at least width, 11 external logic trigger). Address 2 holds the pulse width in samples. A write to address 3 changes nothing.
- R2: `s_ready` is high whenever reset is released. A sample is taken only in a cycle with `s_valid` high. A cycle with `s_valid` low changes no detection state and never causes a trigger in the sample-driven modes.
- R3: Comparison with the threshold is inclusive. A rising crossing is a previous sample below the threshold followed by a current sample at or above it. A falling crossing is a previous sample at or above the threshold followed by a current sample below it.
- R4: In mode 00 a crossing in the selected direction makes `trig_pulse` high for exactly the one cycle after the clock edge that accepted the crossing sample. A crossing in the other direction does nothing.
- R5: A pulse starts on the selected crossing and ends on the opposite crossing. Its length is the number of accepted samples from the starting sample up to, but not including, the ending sample. The length counter saturates at 255.
- R6: In mode 01 the trigger fires on the ending sample when the pulse length is below the width.
- R7: In mode 10 the trigger fires on the ending sample when the pulse length is at or above the width.
- R8: A width value of 3 or less behaves as a width of 4.
- R9: In mode 11 a rising edge of `ext_trig` produces a one-cycle `trig_pulse` in the next cycle, and sample crossings produce no trigger.
- R10: `triggered` goes high together with `trig_pulse` and stays high until `clr_status` is sampled high. If a trigger and a clear occur in the same cycle, the trigger wins.
- R11: After reset, `trig_pulse` and `triggered` are low, the threshold is 0, the edge is rising, the mode is 00 and the effective width is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_data | input | 8 | Configuration write byte |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready (no back-pressure) |
| s_data | input | 10 | Converter sample |
| ext_trig | input | 1 | External logic-combination trigger |
| clr_status | input | 1 | Clears the sticky triggered flag |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky triggered status |

## Verification
The bench puts samples exactly on the threshold. A design with an exclusive compare would fire one sample late on a rising edge, or fire early on a falling edge. It checks pulse lengths one below, at, and one above the width in both pulse modes, which exposes any off-by-one in how the start or end sample is counted. It also exposes a width floor that is missing or off by one, for example a width of 2 accepting a 3-sample pulse. It drives a pulse longer than the counter range: without saturation the count would wrap to a small value and the long-pulse trigger would never fire. Finally, it holds a crossing value on the bus with `s_valid` low, where a design that ignored the handshake would trigger.

// File: rtl/scope_trig_pkg.sv
package scope_trig_pkg;
  typedef enum logic [1:0] {
    TM_LEVEL = 2'b00,
    TM_SHORT = 2'b01,
    TM_LONG  = 2'b10,
    TM_LOGIC = 2'b11
  } trig_mode_e;

  localparam logic [1:0] ADDR_THR_LO = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_WIDTH  = 2'd2;

  localparam int CTRL_POL_BIT  = 2;
  localparam int CTRL_MODE_LSB = 5;
  localparam int MIN_WIDTH     = 4;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import scope_trig_pkg::*;
#(
  parameter int THR_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [BYTE_W-1:0] cfg_data,
  output logic [THR_W-1:0]  thr,
  output logic              fall_sel,
  output trig_mode_e        mode,
  output logic [BYTE_W-1:0] width_eff
);
  localparam int HI_W = THR_W - BYTE_W;

  logic [BYTE_W-1:0] thr_lo_q;
  logic [HI_W-1:0]   thr_hi_q;
  logic              pol_q;
  trig_mode_e        mode_q;
  logic [BYTE_W-1:0] width_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_lo_q <= '0;
      thr_hi_q <= '0;
      pol_q    <= 1'b0;
      mode_q   <= TM_LEVEL;
      width_q  <= '0;
    end else if (cfg_we) begin
      unique case (cfg_addr)
        ADDR_THR_LO: thr_lo_q <= cfg_data;
        ADDR_CTRL: begin
          thr_hi_q <= cfg_data[HI_W-1:0];
          pol_q    <= cfg_data[CTRL_POL_BIT];
          mode_q   <= trig_mode_e'(cfg_data[CTRL_MODE_LSB+1:CTRL_MODE_LSB]);
        end
        ADDR_WIDTH: width_q <= cfg_data;
        default: ;
      endcase
    end
  end

  assign thr       = {thr_hi_q, thr_lo_q};
  assign fall_sel  = pol_q;
  assign mode      = mode_q;
  assign width_eff = (width_q < BYTE_W'(MIN_WIDTH)) ? BYTE_W'(MIN_WIDTH) : width_q;

  // R8
  width_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_WIDTH && cfg_data < BYTE_W'(MIN_WIDTH))
      |=> width_eff == BYTE_W'(MIN_WIDTH));

  // R1
  width_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_WIDTH && cfg_data >= BYTE_W'(MIN_WIDTH))
      |=> width_eff == $past(cfg_data));
endmodule

// File: rtl/trig_cross_det.sv
module trig_cross_det #(
  parameter int THR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [THR_W-1:0] smp,
  input  logic [THR_W-1:0] thr,
  input  logic             fall_sel,
  output logic             start_x,
  output logic             end_x
);
  logic [THR_W-1:0] prev_q;
  logic             prev_ok_q;
  logic             cur_hi, prev_hi, rise_x, fall_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else if (acc) begin
      prev_q    <= smp;
      prev_ok_q <= 1'b1;
    end
  end

  assign cur_hi  = (smp >= thr);
  assign prev_hi = (prev_q >= thr);
  assign rise_x  = acc && prev_ok_q && !prev_hi && cur_hi;
  assign fall_x  = acc && prev_ok_q && prev_hi && !cur_hi;
  assign start_x = fall_sel ? fall_x : rise_x;
  assign end_x   = fall_sel ? rise_x : fall_x;

  // R2
  prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(prev_q));
endmodule

// File: rtl/trig_pulse_meas.sv
module trig_pulse_meas #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             start_x,
  input  logic             end_x,
  output logic             done,
  output logic [CNT_W-1:0] len
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             in_pulse_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pulse_q <= 1'b0;
      cnt_q      <= '0;
    end else if (start_x) begin
      in_pulse_q <= 1'b1;
      cnt_q      <= CNT_W'(1);
    end else if (end_x && in_pulse_q) begin
      in_pulse_q <= 1'b0;
    end else if (acc && in_pulse_q && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = end_x && in_pulse_q;
  assign len  = cnt_q;

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pulse_q && cnt_q == CNT_MAX && !start_x && !end_x) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/scope_trigger.sv
module scope_trigger
  import scope_trig_pkg::*;
#(
  parameter int THR_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [BYTE_W-1:0] cfg_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [THR_W-1:0]  s_data,
  input  logic              ext_trig,
  input  logic              clr_status,
  output logic              trig_pulse,
  output logic              triggered
);
  logic [THR_W-1:0]  thr;
  logic              fall_sel;
  trig_mode_e        mode;
  logic [BYTE_W-1:0] width_eff;
  logic              acc, start_x, end_x, done, fire, ext_q;
  logic [BYTE_W-1:0] len;

  assign s_ready = rst_n;
  assign acc     = s_valid && s_ready;

  trig_cfg_regs #(.THR_W(THR_W), .BYTE_W(BYTE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .thr(thr), .fall_sel(fall_sel), .mode(mode),
    .width_eff(width_eff)
  );

  trig_cross_det #(.THR_W(THR_W)) u_cross (
    .clk(clk), .rst_n(rst_n), .acc(acc), .smp(s_data), .thr(thr),
    .fall_sel(fall_sel), .start_x(start_x), .end_x(end_x)
  );

  trig_pulse_meas #(.CNT_W(BYTE_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .acc(acc), .start_x(start_x), .end_x(end_x),
    .done(done), .len(len)
  );

  always_comb begin
    unique case (mode)
      TM_LEVEL: fire = start_x;
      TM_SHORT: fire = done && (len < width_eff);
      TM_LONG:  fire = done && (len >= width_eff);
      TM_LOGIC: fire = ext_trig && !ext_q;
      default:  fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q      <= 1'b0;
      trig_pulse <= 1'b0;
      triggered  <= 1'b0;
    end else begin
      ext_q      <= ext_trig;
      trig_pulse <= fire;
      triggered  <= fire || (triggered && !clr_status);
    end
  end

  // R2
  no_stream_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && mode != TM_LOGIC && !cfg_we) |=> !trig_pulse);

  // R9
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_LOGIC && ext_trig && !ext_q) |=> trig_pulse);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !clr_status) |=> triggered);

  // R10
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> triggered);
endmodule

// File: tb/scope_trigger_tb_top.sv
module scope_trigger_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [9:0] s_data = '0;
  logic       ext_trig = 1'b0;
  logic       clr_status = 1'b0;
  logic       trig_pulse, triggered;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scope_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .ext_trig(ext_trig), .clr_status(clr_status),
    .trig_pulse(trig_pulse), .triggered(triggered)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // send one sample; returns trig_pulse in the cycle after acceptance
  task automatic send(input int v, output bit fired);
    @(negedge clk);
    s_valid = 1'b1; s_data = 10'(v);
    @(negedge clk);
    s_valid = 1'b0;
    fired = trig_pulse;
  endtask

  task automatic clear_flag();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
  endtask

  // level-rising mode at threshold 512, then a low sample to close any pulse
  task automatic flush();
    bit f;
    wr(2'd0, 8'h00); wr(2'd1, 8'h02);
    send(100, f);
  endtask

  // send n high samples then one low sample; return trigger on the end sample
  task automatic pulse(input int n, input int hi, input int lo, output bit fired);
    bit f;
    for (int i = 0; i < n; i++) send(hi, f);
    send(lo, fired);
  endtask

  task automatic t_reset();
    chk(trig_pulse == 0, "R11 pulse low", trig_pulse, 0);
    chk(triggered == 0, "R11 flag low", triggered, 0);
    chk(s_ready == 1, "R2 ready high", s_ready, 1);
  endtask

  task automatic t_level_rise();
    bit f;
    wr(2'd0, 8'h00); wr(2'd1, 8'h02);
    send(100, f); send(511, f);
    chk(f == 0, "R3 below thr no trig", f, 0);
    send(512, f);
    chk(f == 1, "R3/R4 inclusive rising trig", f, 1);
    @(negedge clk);
    chk(trig_pulse == 0, "R4 one-cycle pulse", trig_pulse, 0);
    chk(triggered == 1, "R10 sticky set", triggered, 1);
    send(300, f);
    chk(f == 0, "R4 opposite edge ignored", f, 0);
    clear_flag();
    chk(triggered == 0, "R10 cleared", triggered, 0);
  endtask

  task automatic t_level_fall();
    bit f;
    wr(2'd1, 8'h06);
    send(600, f); send(512, f);
    chk(f == 0, "R3 at thr stays high", f, 0);
    send(511, f);
    chk(f == 1, "R1/R4 falling trig", f, 1);
    clear_flag();
  endtask

  task automatic t_valid_gap();
    bit f;
    wr(2'd1, 8'h02);
    send(100, f);
    @(negedge clk); s_valid = 1'b0; s_data = 10'd900;
    @(negedge clk);
    @(negedge clk);
    chk(trig_pulse == 0, "R2 invalid sample ignored", trig_pulse, 0);
    send(900, f);
    chk(f == 1, "R2 prev held over gap", f, 1);
    clear_flag();
  endtask

  task automatic t_short();
    bit f;
    flush(); wr(2'd2, 8'd5); wr(2'd1, 8'h22);
    pulse(4, 600, 100, f);
    chk(f == 1, "R6 len4<5 fires", f, 1);
    pulse(5, 600, 100, f);
    chk(f == 0, "R6 len5 no fire", f, 0);
    flush(); wr(2'd1, 8'h26); send(900, f);
    pulse(2, 100, 900, f);
    chk(f == 1, "R5/R6 falling pulse len2 fires", f, 1);
    clear_flag();
  endtask

  task automatic t_long();
    bit f;
    flush(); wr(2'd2, 8'd5); wr(2'd1, 8'h42);
    pulse(5, 600, 100, f);
    chk(f == 1, "R7 len5>=5 fires", f, 1);
    pulse(4, 600, 100, f);
    chk(f == 0, "R7 len4 no fire", f, 0);
    pulse(6, 600, 100, f);
    chk(f == 1, "R7 len6 fires", f, 1);
    clear_flag();
  endtask

  task automatic t_min_width();
    bit f;
    flush(); wr(2'd2, 8'd2); wr(2'd1, 8'h42);
    pulse(3, 600, 100, f);
    chk(f == 0, "R8 width2 as 4, len3 no fire", f, 0);
    pulse(4, 600, 100, f);
    chk(f == 1, "R8 width2 as 4, len4 fires", f, 1);
    clear_flag();
  endtask

  task automatic t_saturate();
    bit f;
    flush(); wr(2'd2, 8'd255); wr(2'd1, 8'h42);
    pulse(300, 600, 100, f);
    chk(f == 1, "R5 counter saturates", f, 1);
    clear_flag();
  endtask

  task automatic t_logic();
    bit f;
    flush(); wr(2'd1, 8'h62);
    send(100, f); send(900, f);
    chk(f == 0, "R9 crossing ignored", f, 0);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk);
    chk(trig_pulse == 1, "R9 ext rise fires", trig_pulse, 1);
    @(negedge clk);
    chk(trig_pulse == 0, "R9 single pulse", trig_pulse, 0);
    ext_trig = 1'b0;
    // clear together with a new trigger: trigger wins
    @(negedge clk); ext_trig = 1'b1; clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0; ext_trig = 1'b0;
    chk(triggered == 1, "R10 set wins over clear", triggered, 1);
    clear_flag();
  endtask

  task automatic t_addr3();
    bit f;
    flush();
    wr(2'd3, 8'hFF);
    send(511, f);
    chk(f == 0, "R1 addr3 no thr change", f, 0);
    send(512, f);
    chk(f == 1, "R1 addr3 no mode change", f, 1);
    clear_flag();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level_rise();
        t_level_fall();
        t_valid_gap();
        t_short();
        t_long();
        t_min_width();
        t_saturate();
        t_logic();
        t_addr3();
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule